// File: doc/BRIEF.md
# Serial Word Packet Assembler

This block sits behind a serial receiver and groups the words it delivers into packets. Each incoming word arrives with a one-cycle valid strobe, the timestamp of the start of its frame, and the current value of the shared timebase. The word is passed on one cycle later, tagged with a first flag and a last flag. A packet-start pulse marks the first word. The start and end timestamps of the packet are presented on dedicated outputs. Two closing criteria are available. One is a delimiter value, and the delimiter word belongs to the packet it ends. The other is a word-count limit. Whichever criterion is met first closes the packet.

Each criterion is switched off by a negative configuration value, so -1 means "off". When both are off, the block only forwards words: no packets are formed, the flags stay low and the timestamps hold. The packet length cannot exceed a parameterised depth. When a packet reaches that depth without meeting either criterion, it is forced closed and an overflow flag marks the closing word. A three-state controller tracks the framing. PA_BYPASS is active while both criteria are off. PA_EMPTY means no packet is open. PA_OPEN means a packet has started but not yet closed. The controller has four transitions. "enable" goes from PA_BYPASS to PA_EMPTY, or directly to PA_OPEN when a non-closing word arrives in the same cycle. "open" goes from PA_EMPTY to PA_OPEN on a non-closing word. "close" goes from PA_OPEN to PA_EMPTY on a closing word. "disable" goes from any state to PA_BYPASS when both criteria become off. A closing word that arrives in PA_EMPTY forms a one-word packet, and the state stays PA_EMPTY.

Top module: `pkt_asm`

## Requirements
- R1: After reset, out_valid, out_first, out_last, out_overflow and pkt_start are 0, and both timestamp outputs are 0.
- R2: Each word accepted with in_valid appears on out_data exactly one clock later, with out_valid high for that one cycle only. out_valid is low in every cycle that does not follow an accepted word.
- R3: The first word of a packet has out_first=1 and pkt_start=1 in the same cycle. pkt_start_stamp takes that word's in_stamp in that cycle and holds it until the next packet starts.
- R4: The delimiter is enabled when the sign bit cfg_delim[WORD_W] is 0. An enabled delimiter compares against cfg_delim[WORD_W-1:0]. A word equal to that value closes the packet and is output with out_last=1.
- R5: The length limit is enabled when cfg_len, read as a signed number, is greater than 0. The word that brings the packet's word count to cfg_len is output with out_last=1.
- R6: When both criteria are enabled, the one met first closes the packet. The word count starts again from zero for the next packet.
- R7: The word that follows a closing word starts a new packet, with out_first=1.
- R8: A packet of one word has out_first and out_last both set on that word.
- R9: If a packet reaches DEPTH words without a delimiter or length match, the DEPTH-th word has out_last=1 and out_overflow=1. out_overflow is never set on any other word. If the length limit equals DEPTH exactly, the packet closes without overflow.
- R10: pkt_end_stamp takes the value of cur_time from the cycle the closing word was accepted. It appears in the same cycle as out_last and holds until the next close.
- R11: When both criteria are disabled, words are still forwarded under R2. out_first, out_last, out_overflow and pkt_start stay 0, and both timestamps hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_delim | input | WORD_W+1 | Sign bit set disables the delimiter; the low bits hold the delimiter value |
| cfg_len | input | LEN_W | Signed word-count limit; a value of 0 or less disables it |
| in_valid | input | 1 | A received word is present |
| in_data | input | WORD_W | Received word |
| in_stamp | input | TS_W | Start time of this word's frame |
| cur_time | input | TS_W | Current timebase, taken as the completion time of the word |
| out_valid | output | 1 | Forwarded word present |
| out_data | output | WORD_W | Forwarded word |
| out_first | output | 1 | Word opens a packet |
| out_last | output | 1 | Word closes a packet |
| out_overflow | output | 1 | Packet was forced closed at DEPTH words |
| pkt_start | output | 1 | Packet-start marker |
| pkt_start_stamp | output | TS_W | Start time of the current or last packet |
| pkt_end_stamp | output | TS_W | End time of the last closed packet |

## Verification
A word count that drifts from the true position in the packet shows up at the ports in two ways. The out_last flag lands on the wrong word of a length-closed packet, and the overflow flag lands one word early or late. Both are visible within one packet, at most DEPTH words later. A controller left in PA_OPEN after a close shows up at once: the next word arrives without out_first and pkt_start. A timestamp captured on the wrong word shows up in the same cycle as the pkt_start or out_last it accompanies.

// File: rtl/pkt_asm_pkg.sv
package pkt_asm_pkg;

    typedef enum logic [1:0] {
        PA_BYPASS = 2'd0,
        PA_EMPTY  = 2'd1,
        PA_OPEN   = 2'd2
    } pa_state_e;

    typedef struct packed {
        logic bypass;
        logic delim_hit;
        logic len_hit;
        logic full_hit;
    } pa_match_t;

endpackage

// File: rtl/pkt_asm_match.sv
module pkt_asm_match
    import pkt_asm_pkg::*;
#(
    parameter int WORD_W = 8,
    parameter int LEN_W  = 8,
    parameter int DEPTH  = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic [WORD_W:0]   cfg_delim,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic [WORD_W-1:0] data,
    input  logic [CNT_W-1:0]  count,
    output pa_match_t         match
);

    logic             delim_on;
    logic             len_on;
    logic [CNT_W-1:0] next_count;

    always_comb begin
        // a negative setting switches a criterion off
        delim_on   = ~cfg_delim[WORD_W];
        len_on     = ~cfg_len[LEN_W-1] && (cfg_len != '0);
        next_count = count + CNT_W'(1);

        match.bypass    = ~delim_on && ~len_on;
        match.delim_hit = delim_on && (data == cfg_delim[WORD_W-1:0]);
        match.len_hit   = len_on && (cfg_len == LEN_W'(next_count));
        match.full_hit  = ~match.bypass && (next_count == CNT_W'(DEPTH));
    end

endmodule

// File: rtl/pkt_asm_count.sv
module pkt_asm_count #(
    parameter int DEPTH  = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            count <= '0;
        end else if (inc) begin
            count <= count + CNT_W'(1);
        end
    end

endmodule

// File: rtl/pkt_asm_fsm.sv
module pkt_asm_fsm
    import pkt_asm_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      in_valid,
    input  logic      bypass,
    input  logic      close,
    output pa_state_e state,
    output logic      is_first
);

    pa_state_e state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= PA_EMPTY;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        if (bypass) begin
            state_nx = PA_BYPASS;                        // disable
        end else begin
            unique case (state)
                PA_BYPASS, PA_EMPTY: begin
                    if (in_valid && !close) state_nx = PA_OPEN;   // open / enable
                    else                    state_nx = PA_EMPTY;  // enable
                end
                PA_OPEN: begin
                    if (in_valid && close) state_nx = PA_EMPTY;   // close
                end
                default: state_nx = PA_EMPTY;
            endcase
        end
    end

    always_comb begin
        is_first = (state != PA_OPEN) && !bypass;
    end

endmodule

// File: rtl/pkt_asm_out.sv
module pkt_asm_out #(
    parameter int WORD_W = 8,
    parameter int TS_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_data,
    input  logic [TS_W-1:0]   in_stamp,
    input  logic [TS_W-1:0]   cur_time,
    input  logic              tag_first,
    input  logic              tag_last,
    input  logic              tag_ovf,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_data,
    output logic              out_first,
    output logic              out_last,
    output logic              out_overflow,
    output logic              pkt_start,
    output logic [TS_W-1:0]   pkt_start_stamp,
    output logic [TS_W-1:0]   pkt_end_stamp
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid       <= 1'b0;
            out_data        <= '0;
            out_first       <= 1'b0;
            out_last        <= 1'b0;
            out_overflow    <= 1'b0;
            pkt_start       <= 1'b0;
            pkt_start_stamp <= '0;
            pkt_end_stamp   <= '0;
        end else begin
            out_valid    <= in_valid;
            out_first    <= in_valid && tag_first;
            out_last     <= in_valid && tag_last;
            out_overflow <= in_valid && tag_ovf;
            pkt_start    <= in_valid && tag_first;
            if (in_valid) begin
                out_data <= in_data;
            end
            if (in_valid && tag_first) begin
                pkt_start_stamp <= in_stamp;
            end
            if (in_valid && tag_last) begin
                pkt_end_stamp <= cur_time;
            end
        end
    end

endmodule

// File: rtl/pkt_asm.sv
module pkt_asm
    import pkt_asm_pkg::*;
#(
    parameter int WORD_W = 8,
    parameter int LEN_W  = 8,
    parameter int DEPTH  = 16,
    parameter int TS_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W:0]   cfg_delim,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_data,
    input  logic [TS_W-1:0]   in_stamp,
    input  logic [TS_W-1:0]   cur_time,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_data,
    output logic              out_first,
    output logic              out_last,
    output logic              out_overflow,
    output logic              pkt_start,
    output logic [TS_W-1:0]   pkt_start_stamp,
    output logic [TS_W-1:0]   pkt_end_stamp
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    pa_match_t        match;
    pa_state_e        state;
    logic [CNT_W-1:0] count;
    logic             close;
    logic             is_first;
    logic             tag_first;
    logic             tag_last;
    logic             tag_ovf;

    pkt_asm_match #(
        .WORD_W (WORD_W),
        .LEN_W  (LEN_W),
        .DEPTH  (DEPTH)
    ) u_match (
        .cfg_delim (cfg_delim),
        .cfg_len   (cfg_len),
        .data      (in_data),
        .count     (count),
        .match     (match)
    );

    always_comb begin
        close     = match.delim_hit || match.len_hit || match.full_hit;
        tag_first = is_first;
        tag_last  = !match.bypass && close;
        tag_ovf   = match.full_hit && !match.delim_hit && !match.len_hit;
    end

    pkt_asm_count #(
        .DEPTH (DEPTH)
    ) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (match.bypass || (in_valid && close)),
        .inc   (in_valid),
        .count (count)
    );

    pkt_asm_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .bypass   (match.bypass),
        .close    (close),
        .state    (state),
        .is_first (is_first)
    );

    pkt_asm_out #(
        .WORD_W (WORD_W),
        .TS_W   (TS_W)
    ) u_out (
        .clk             (clk),
        .rst_n           (rst_n),
        .in_valid        (in_valid),
        .in_data         (in_data),
        .in_stamp        (in_stamp),
        .cur_time        (cur_time),
        .tag_first       (tag_first),
        .tag_last        (tag_last),
        .tag_ovf         (tag_ovf),
        .out_valid       (out_valid),
        .out_data        (out_data),
        .out_first       (out_first),
        .out_last        (out_last),
        .out_overflow    (out_overflow),
        .pkt_start       (pkt_start),
        .pkt_start_stamp (pkt_start_stamp),
        .pkt_end_stamp   (pkt_end_stamp)
    );

endmodule

// File: rtl/pkt_asm_chk.sv
module pkt_asm_chk #(
    parameter int WORD_W = 8,
    parameter int LEN_W  = 8,
    parameter int DEPTH  = 16,
    parameter int TS_W   = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [WORD_W:0]   cfg_delim,
    input logic [LEN_W-1:0]  cfg_len,
    input logic              in_valid,
    input logic [WORD_W-1:0] in_data,
    input logic              out_valid,
    input logic [WORD_W-1:0] out_data,
    input logic              out_first,
    input logic              out_last,
    input logic              out_overflow,
    input logic              pkt_start,
    input logic [TS_W-1:0]   pkt_start_stamp,
    input logic [TS_W-1:0]   pkt_end_stamp
);

    localparam int WC_W = $clog2(DEPTH + 2);

    logic [WC_W-1:0] words;
    logic [WC_W-1:0] words_now;
    logic            both_off;

    always_comb begin
        both_off  = cfg_delim[WORD_W] && (cfg_len[LEN_W-1] || cfg_len == '0);
        words_now = out_first ? WC_W'(1) : words + WC_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            words <= '0;
        end else if (out_valid) begin
            words <= words_now;
        end
    end

    // R2
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid && out_data == $past(in_data));

    // R2
    idle_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R3
    start_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_start |-> out_valid && out_first);

    // R3
    start_stamp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pkt_start |-> $stable(pkt_start_stamp));

    // R4
    delim_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !cfg_delim[WORD_W] && in_data == cfg_delim[WORD_W-1:0]) |=> out_last);

    // R9
    ovf_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_overflow |-> out_last && words_now == WC_W'(DEPTH));

    // R10
    end_stamp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_valid && out_last) |-> $stable(pkt_end_stamp));

    // R11
    bypass_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && both_off) |=> !out_first && !out_last && !pkt_start && !out_overflow);

endmodule

bind pkt_asm pkt_asm_chk #(
    .WORD_W (WORD_W),
    .LEN_W  (LEN_W),
    .DEPTH  (DEPTH),
    .TS_W   (TS_W)
) u_pkt_asm_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .cfg_delim       (cfg_delim),
    .cfg_len         (cfg_len),
    .in_valid        (in_valid),
    .in_data         (in_data),
    .out_valid       (out_valid),
    .out_data        (out_data),
    .out_first       (out_first),
    .out_last        (out_last),
    .out_overflow    (out_overflow),
    .pkt_start       (pkt_start),
    .pkt_start_stamp (pkt_start_stamp),
    .pkt_end_stamp   (pkt_end_stamp)
);

// File: tb/pkt_asm_test.sv
module pkt_asm_test;

    localparam int WORD_W = 8;
    localparam int LEN_W  = 8;
    localparam int DEPTH  = 16;
    localparam int TS_W   = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [WORD_W:0]   cfg_delim = '1;
    logic [LEN_W-1:0]  cfg_len = '1;
    logic              in_valid = 1'b0;
    logic [WORD_W-1:0] in_data = '0;
    logic [TS_W-1:0]   in_stamp = '0;
    logic [TS_W-1:0]   cur_time = '0;
    logic              out_valid;
    logic [WORD_W-1:0] out_data;
    logic              out_first;
    logic              out_last;
    logic              out_overflow;
    logic              pkt_start;
    logic [TS_W-1:0]   pkt_start_stamp;
    logic [TS_W-1:0]   pkt_end_stamp;

    int n_checks = 0;
    int n_fails  = 0;
    logic [TS_W-1:0] exp_start = '0;
    logic [TS_W-1:0] exp_end   = '0;
    int stamp_seq = 100;

    always #4 clk = ~clk;

    pkt_asm #(
        .WORD_W (WORD_W), .LEN_W (LEN_W), .DEPTH (DEPTH), .TS_W (TS_W)
    ) uut (
        .clk (clk), .rst_n (rst_n), .cfg_delim (cfg_delim), .cfg_len (cfg_len),
        .in_valid (in_valid), .in_data (in_data), .in_stamp (in_stamp),
        .cur_time (cur_time), .out_valid (out_valid), .out_data (out_data),
        .out_first (out_first), .out_last (out_last), .out_overflow (out_overflow),
        .pkt_start (pkt_start), .pkt_start_stamp (pkt_start_stamp),
        .pkt_end_stamp (pkt_end_stamp)
    );

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // drive one word and check the forwarded result one clock later
    task automatic send(input logic [WORD_W-1:0] d, input logic f, input logic l,
                        input logic ov, input string req);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = d;
        in_stamp = TS_W'(stamp_seq);
        cur_time = TS_W'(stamp_seq + 9);
        if (f) exp_start = TS_W'(stamp_seq);
        if (l) exp_end   = TS_W'(stamp_seq + 9);
        stamp_seq += 10;
        @(negedge clk);
        in_valid = 1'b0;
        check(req, "out_valid", 64'(out_valid), 64'd1);
        check(req, "out_data", 64'(out_data), 64'(d));
        check(req, "out_first", 64'(out_first), 64'(f));
        check(req, "pkt_start", 64'(pkt_start), 64'(f));
        check(req, "out_last", 64'(out_last), 64'(l));
        check(req, "out_overflow", 64'(out_overflow), 64'(ov));
        check("R10", "pkt_end_stamp", 64'(pkt_end_stamp), 64'(exp_end));
        check("R3", "pkt_start_stamp", 64'(pkt_start_stamp), 64'(exp_start));
        @(negedge clk);
        check("R2", "out_valid idle", 64'(out_valid), 64'd0);
    endtask

    task automatic t_reset();
        check("R1", "out_valid", 64'(out_valid), 64'd0);
        check("R1", "flags", 64'({out_first, out_last, out_overflow, pkt_start}), 64'd0);
        check("R1", "stamps", 64'({pkt_start_stamp, pkt_end_stamp}), 64'd0);
    endtask

    task automatic t_delim();
        cfg_delim = 9'h00A; cfg_len = '1;
        send(8'h41, 1, 0, 0, "R4");
        send(8'h42, 0, 0, 0, "R4");
        send(8'h0A, 0, 1, 0, "R4");
        send(8'h0A, 1, 1, 0, "R8");
        send(8'h43, 1, 0, 0, "R7");
        send(8'h0A, 0, 1, 0, "R4");
    endtask

    task automatic t_len();
        cfg_delim = '1; cfg_len = 8'd4;
        for (int p = 0; p < 2; p++)
            for (int i = 0; i < 4; i++)
                send(8'h0A + 8'(i), i == 0, i == 3, 0, "R5");
        cfg_len = 8'd1;
        send(8'h55, 1, 1, 0, "R8");
    endtask

    task automatic t_both();
        cfg_delim = 9'h00A; cfg_len = 8'd5;
        send(8'h11, 1, 0, 0, "R6");
        send(8'h12, 0, 0, 0, "R6");
        send(8'h0A, 0, 1, 0, "R6");
        for (int i = 0; i < 5; i++)
            send(8'h20 + 8'(i), i == 0, i == 4, 0, "R6");
    endtask

    task automatic t_overflow();
        cfg_delim = 9'h00A; cfg_len = 8'd100;
        for (int i = 0; i < DEPTH; i++)
            send(8'h30 + 8'(i), i == 0, i == DEPTH - 1, i == DEPTH - 1, "R9");
        cfg_len = 8'(DEPTH);
        for (int i = 0; i < DEPTH; i++)
            send(8'h30 + 8'(i), i == 0, i == DEPTH - 1, 0, "R9");
        cfg_len = 8'd0;
        for (int i = 0; i < DEPTH; i++)
            send(8'h50 + 8'(i), i == 0, i == DEPTH - 1, i == DEPTH - 1, "R9");
    endtask

    task automatic t_bypass();
        cfg_delim = '1; cfg_len = '1;
        send(8'h0A, 0, 0, 0, "R11");
        send(8'h77, 0, 0, 0, "R11");
        cfg_len = 8'd0;
        send(8'h00, 0, 0, 0, "R11");
        cfg_delim = 9'h00A; cfg_len = '1;
        send(8'h61, 1, 0, 0, "R7");
        send(8'h0A, 0, 1, 0, "R4");
    endtask

    initial begin
        fork
            begin
                repeat (4) @(negedge clk);
                rst_n = 1'b1;
                @(negedge clk);
                t_reset();
                t_delim();
                t_len();
                t_both();
                t_overflow();
                t_bypass();
            end
            begin
                repeat (20000) @(posedge clk);
                n_checks++;
                n_fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule